// File: doc/BRIEF.md
# Programmable PN Code Generator

This block produces a pseudo-random chip stream for spreading or despreading in a direct-sequence link. The code is a maximal-length shift-register sequence of order n, with n chosen at run time between 7 and 13. A zero state is inserted into the cycle, so one code period is exactly 2^n chips. A chip system typically places two of these blocks side by side, one for the transmit path and one for the receive path, each with its own settings.

The block runs from a master clock at sixteen times the nominal chip rate. A sub-chip countdown sets the spacing between chip strobes, so the code phase can be moved in steps of one sixteenth of a chip by stretching or shrinking a single chip interval.

Three controls act on the phase:
- A tau-dither control holds the phase early or late of the tracked point by a programmable number of sixteenths.
- A slip control pulls the phase forward by one sixteenth per chip while it is held, which sweeps the code across offsets during acquisition.
- An enable freezes the generator in place.

Each new chip is flagged by a one-clock strobe. A one-clock epoch pulse marks the first chip of every period.

Top module: `pn_code_gen`

## Requirements
- R1: While reset is low, `chip_stb_o` and `epoch_o` are 0. After reset the first strobe comes on the 16th enabled clock, and it carries an epoch.
- R2: With dither disabled and slip low, consecutive strobes are exactly 16 enabled clocks apart.
- R3: `epoch_o` is high only together with `chip_stb_o`. A period holds exactly 2^n strobes from one epoch to the next. Here n is `order_i` sampled at the epoch that opens the period, with values below 7 taken as 7 and values above 13 taken as 13.
- R4: `chip_o` changes only in a strobe cycle. Over one period, the chips read at the strobes contain every n-bit circular window exactly once, so exactly 2^(n-1) of them are 1.
- R5: On an epoch, `chip_o` equals bit n-1 of `seed_i` as sampled at that epoch. Changes to `order_i` or `seed_i` made in mid-period do not alter the period in progress.
- R6: The dither target offset T is +A when `dith_late_i`=1 and -A when `dith_late_i`=0, in sixteenths, where A = `dith_amp_i` (0 to 7). T is 0 when `dith_en_i`=0. Suppose the inputs at strobe edge k give target T_k. Then the interval from strobe k to strobe k+1 is 16 + T_k - T_(k-1) enabled clocks, and T is 0 before the first strobe.
- R7: If `slip_i` is high at a strobe edge, the interval that starts at that strobe is one clock shorter than R6 gives. The minimum interval, early jump of 14 combined with slip, is 1 clock.
- R8: A clock with `en_i` low produces no strobe in the following cycle and leaves `chip_o` unchanged. The interval count resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 16x chip rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low freezes the generator |
| order_i | input | 4 | Register order n, clamped to 7..13, taken at epoch |
| seed_i | input | 13 | Start state, low n bits used, taken at epoch |
| dith_en_i | input | 1 | Enable tau-dither offset |
| dith_late_i | input | 1 | 1 = late offset, 0 = early offset |
| dith_amp_i | input | 3 | Dither amplitude A in sixteenths of a chip |
| slip_i | input | 1 | Shorten each chip interval by one clock |
| chip_o | output | 1 | Current code chip |
| chip_stb_o | output | 1 | One-clock pulse when a new chip appears |
| epoch_o | output | 1 | One-clock pulse on the first chip of a period |

## Verification
The strobe, the epoch flag and the new chip value all appear in the cycle after the enabled edge on which the sub-chip count reaches zero. Dither and slip settings that change after strobe k are first sampled at the edge that produces strobe k+1. Their effect is therefore due in the interval that ends at strobe k+2. The driver records this target strobe index with each expected interval. The monitor counts strobes and measures each interval in enabled clocks, so an expected value is matched only against the interval it belongs to. Order and seed changes are checked one full period later, at the epoch where the monitor closes the period with the order it latched at the previous epoch.

// File: rtl/pn_pkg.sv
package pn_pkg;
  localparam int unsigned PN_TAB_MAX = 13;
  typedef logic [PN_TAB_MAX-1:0] pn_word_t;

  // feedback masks of primitive polynomials, bit k-1 for term x^k
  function automatic pn_word_t pn_taps(input int unsigned n);
    case (n)
      7:       return 13'h0060;
      8:       return 13'h00B8;
      9:       return 13'h0110;
      10:      return 13'h0240;
      11:      return 13'h0500;
      12:      return 13'h0E08;
      default: return 13'h1C80;
    endcase
  endfunction

  function automatic int unsigned pn_clamp(input int unsigned n, input int unsigned lo,
                                           input int unsigned hi);
    if (n < lo) return lo;
    if (n > hi) return hi;
    return n;
  endfunction
endpackage

// File: rtl/pn_phase_ctl.sv
module pn_phase_ctl #(
  parameter int unsigned SUB_W = 4,
  parameter int unsigned AMP_W = 3,
  localparam int unsigned NOM   = 1 << SUB_W,
  localparam int unsigned CNT_W = $clog2(NOM + 2 * ((1 << AMP_W) - 1))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dith_en_i,
  input  logic             dith_late_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic             slip_i,
  output logic             tick_o
);
  logic [CNT_W-1:0]        cnt_q;
  logic signed [AMP_W+1:0] tgt, app_q;
  int                      len_c;

  always_comb begin
    if (!dith_en_i)       tgt = '0;
    else if (dith_late_i) tgt = $signed({2'b00, amp_i});
    else                  tgt = -$signed({2'b00, amp_i});
    // interval moves by the change in offset since the last chip
    len_c  = int'(NOM) + int'(tgt) - int'(app_q) - int'(slip_i);
    tick_o = en_i && (cnt_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(NOM - 1);
      app_q <= '0;
    end else if (tick_o) begin
      cnt_q <= CNT_W'(len_c - 1);
      app_q <= tgt;
    end else if (en_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pn_seq_gen.sv
module pn_seq_gen
  import pn_pkg::*;
#(
  parameter int unsigned MIN_ORDER = 7,
  parameter int unsigned MAX_ORDER = 13,
  localparam int unsigned ORD_W = $clog2(MAX_ORDER + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic [ORD_W-1:0]     order_i,
  input  logic [MAX_ORDER-1:0] seed_i,
  output logic                 chip_o,
  output logic                 epoch_o
);
  logic [MAX_ORDER-1:0] st_q, idx_q, mask, next_mask, taps, st_adv;
  logic [ORD_W-1:0]     ord_q, ord_new;
  pn_word_t             taps_full;
  logic                 wrap, fb, epoch_q;

  always_comb begin
    taps_full = pn_taps(int'(ord_q));
    taps      = taps_full[MAX_ORDER-1:0];
    mask      = MAX_ORDER'((64'd1 << ord_q) - 64'd1);
    ord_new   = ORD_W'(pn_clamp(int'(order_i), MIN_ORDER, MAX_ORDER));
    next_mask = MAX_ORDER'((64'd1 << ord_new) - 64'd1);
    wrap      = &(idx_q | ~mask);
    // inverting feedback when the low n-1 bits are zero splices in the zero state
    fb        = (^(st_q & taps)) ^ ~|(st_q & (mask >> 1));
    st_adv    = {st_q[MAX_ORDER-2:0], fb} & mask;
    chip_o    = |(st_q & mask & ~(mask >> 1));
    epoch_o   = epoch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      idx_q   <= '1;
      ord_q   <= ORD_W'(MIN_ORDER);
      epoch_q <= 1'b0;
    end else begin
      epoch_q <= adv_i && wrap;
      if (adv_i) begin
        if (wrap) begin
          ord_q <= ord_new;
          st_q  <= seed_i & next_mask;
          idx_q <= '0;
        end else begin
          st_q  <= st_adv;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pn_code_gen.sv
module pn_code_gen #(
  parameter int unsigned MIN_ORDER = 7,
  parameter int unsigned MAX_ORDER = 13,
  parameter int unsigned SUB_W     = 4,
  parameter int unsigned AMP_W     = 3,
  localparam int unsigned ORD_W = $clog2(MAX_ORDER + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [ORD_W-1:0]     order_i,
  input  logic [MAX_ORDER-1:0] seed_i,
  input  logic                 dith_en_i,
  input  logic                 dith_late_i,
  input  logic [AMP_W-1:0]     dith_amp_i,
  input  logic                 slip_i,
  output logic                 chip_o,
  output logic                 chip_stb_o,
  output logic                 epoch_o
);
  logic tick, stb_q;

  pn_phase_ctl #(.SUB_W(SUB_W), .AMP_W(AMP_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .dith_en_i  (dith_en_i),
    .dith_late_i(dith_late_i),
    .amp_i      (dith_amp_i),
    .slip_i     (slip_i),
    .tick_o     (tick)
  );

  pn_seq_gen #(.MIN_ORDER(MIN_ORDER), .MAX_ORDER(MAX_ORDER)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (tick),
    .order_i(order_i),
    .seed_i (seed_i),
    .chip_o (chip_o),
    .epoch_o(epoch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= tick;
  end

  assign chip_stb_o = stb_q;
endmodule

// File: rtl/pn_code_gen_chk.sv
module pn_code_gen_chk #(
  parameter int unsigned MIN_ORDER = 7,
  parameter int unsigned MAX_ORDER = 13,
  localparam int unsigned ORD_W = $clog2(MAX_ORDER + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [ORD_W-1:0] order_i,
  input logic             chip_o,
  input logic             chip_stb_o,
  input logic             epoch_o
);
  logic [ORD_W-1:0]   ord_prev;
  logic [MAX_ORDER:0] cnt_q, len_q;
  logic               seen_q;
  int unsigned        ord_c;

  always_comb begin
    ord_c = int'(ord_prev);
    if (ord_c < MIN_ORDER) ord_c = MIN_ORDER;
    if (ord_c > MAX_ORDER) ord_c = MAX_ORDER;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ord_prev <= '0;
      cnt_q    <= '0;
      len_q    <= '0;
      seen_q   <= 1'b0;
    end else begin
      ord_prev <= order_i;
      if (epoch_o) begin
        seen_q <= 1'b1;
        cnt_q  <= (MAX_ORDER+1)'(1);
        len_q  <= (MAX_ORDER+1)'(64'd1 << ord_c);
      end else if (chip_stb_o) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  AST_EPOCH_WITH_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_o |-> chip_stb_o); // R3
  AST_PERIOD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epoch_o && seen_q) |-> (cnt_q == len_q)); // R3
  AST_CHIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_stb_o |-> $stable(chip_o)); // R4
  AST_FREEZE_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !chip_stb_o); // R8
  AST_FREEZE_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(chip_o)); // R8
endmodule

bind pn_code_gen pn_code_gen_chk #(.MIN_ORDER(MIN_ORDER), .MAX_ORDER(MAX_ORDER)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .order_i   (order_i),
  .chip_o    (chip_o),
  .chip_stb_o(chip_stb_o),
  .epoch_o   (epoch_o)
);

// File: tb/pn_code_gen_tb.sv
module pn_code_gen_tb;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic        den = 1'b0, dlate = 1'b0, slip = 1'b0;
  logic [3:0]  ord = 4'd7;
  logic [12:0] seed = 13'h0055;
  logic [2:0]  amp = 3'd0;
  logic        chip, stb, ep;

  always #10 clk = ~clk;

  pn_code_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .order_i(ord), .seed_i(seed),
    .dith_en_i(den), .dith_late_i(dlate), .dith_amp_i(amp), .slip_i(slip),
    .chip_o(chip), .chip_stb_o(stb), .epoch_o(ep)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct { int idx; int iv; string req; } exp_t;
  exp_t q[$];

  // scoreboard state
  int          since = 0, mark = 0, stb_n = 0, pcnt = 0, pn = 7, exp_order = 7;
  bit          started = 1'b0;
  bit          pbuf [8192];
  logic [12:0] exp_seed = 13'h0055;

  always @(posedge clk) if (rst_n && en) since <= since + 1;

  task automatic check_period();
    bit seen [8192];
    int len, dup, ones, w;
    len = 1 << pn;
    chk(pcnt == len, "R3 period length", pcnt, len);
    if (pcnt == len) begin
      dup = 0; ones = 0;
      for (int i = 0; i < len; i++) seen[i] = 1'b0;
      for (int i = 0; i < len; i++) begin
        w = 0;
        for (int j = 0; j < pn; j++) w = (w << 1) | int'(pbuf[(i + j) % len]);
        if (seen[w]) dup++;
        seen[w] = 1'b1;
        ones += int'(pbuf[i]);
      end
      chk(dup == 0, "R4 window repeats", dup, 0);
      chk(ones == len / 2, "R4 ones count", ones, len / 2);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ep && !stb) chk(1'b0, "R3 epoch without strobe", 0, 1);
      if (stb) begin
        int iv;
        iv = since - mark;
        mark = since;
        stb_n++;
        if (q.size() > 0 && q[0].idx == stb_n) begin
          chk(iv == q[0].iv, q[0].req, iv, q[0].iv);
          void'(q.pop_front());
        end
        if (ep) begin
          if (started) check_period();
          started = 1'b1;
          pn = exp_order;
          chk(chip == exp_seed[pn-1], "R5 first chip", int'(chip), int'(exp_seed[pn-1]));
          pcnt = 0;
        end
        if (pcnt < 8192) pbuf[pcnt] = chip;
        pcnt++;
      end
    end
  end

  task automatic wait_stb();
    do begin @(negedge clk); #1; end while (!stb);
  endtask

  task automatic wait_epoch();
    do begin @(negedge clk); #1; end while (!ep);
  endtask

  int prev_t = 0;
  task automatic step(input bit de, input bit lt, input int a, input bit sl, input string req);
    int t;
    wait_stb();
    den = de; dlate = lt; amp = 3'(a); slip = sl;
    t = de ? (lt ? a : -a) : 0;
    q.push_back('{stb_n + 2, 16 + t - prev_t - int'(sl), req});
    prev_t = t;
  endtask

  // driver
  initial begin
    int bad;
    logic c0;
    #5;
    chk(stb == 1'b0 && ep == 1'b0, "R1 outputs in reset", int'(stb | ep), 0);
    repeat (3) @(negedge clk);
    chk(stb == 1'b0 && ep == 1'b0, "R1 outputs in reset", int'(stb | ep), 0);
    q.push_back('{1, 16, "R1 first interval"});
    rst_n = 1'b1; en = 1'b1;
    wait_stb();
    chk(ep == 1'b1, "R1 first strobe is epoch", int'(ep), 1);

    step(1'b0, 1'b0, 0, 1'b0, "R2 nominal interval");
    step(1'b1, 1'b1, 5, 1'b0, "R6 late jump");
    step(1'b1, 1'b0, 5, 1'b0, "R6 late to early");
    step(1'b1, 1'b0, 5, 1'b0, "R6 hold early");
    step(1'b1, 1'b1, 7, 1'b0, "R6 early to late max");
    step(1'b1, 1'b0, 7, 1'b1, "R7 min interval");
    step(1'b0, 1'b0, 0, 1'b1, "R7 release with slip");
    step(1'b0, 1'b0, 0, 1'b1, "R7 slip interval");
    step(1'b0, 1'b0, 0, 1'b0, "R2 back to nominal");

    // R8 freeze
    wait_stb();
    repeat (5) @(negedge clk);
    en = 1'b0;
    c0 = chip;
    bad = 0;
    @(negedge clk);
    repeat (20) begin
      @(negedge clk);
      if (stb) bad++;
      if (chip !== c0) bad++;
    end
    chk(bad == 0, "R8 freeze", bad, 0);
    q.push_back('{stb_n + 1, 16, "R8 resumed interval"});
    en = 1'b1;

    // order and seed changes, mid-period
    wait_epoch();
    repeat (10) wait_stb();
    ord = 4'd3; exp_order = 7; seed = 13'h002A; exp_seed = 13'h002A;
    wait_epoch();
    slip = 1'b1;
    repeat (10) wait_stb();
    ord = 4'd10; exp_order = 10; seed = 13'h1A5B; exp_seed = 13'h1A5B;
    wait_epoch();
    repeat (10) wait_stb();
    ord = 4'd14; exp_order = 13; seed = 13'h0000; exp_seed = 13'h0000;
    wait_epoch();
    repeat (10) wait_stb();
    ord = 4'd7; exp_order = 7; seed = 13'h007F; exp_seed = 13'h007F;
    wait_epoch();
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule